// File: doc/BRIEF.md
# Serial Register Access Port

This block is a slave-side serial port through which an external host reads and writes registers inside a converter-style device. It holds a 24-bit control register and presents a read-only 24-bit result word supplied by the surrounding logic. A host opens a transaction by pulling chip select low. It then clocks in an 8-bit instruction and moves one to three data bytes.

Three bits of the control register set how the port behaves on the next transaction. One bit routes read data to the shared bidirectional line or to a dedicated output line. One bit makes multi-byte accesses walk the byte lanes upward or downward. One bit sends each byte least- or most-significant bit first. Because the port writes these bits itself, a host can reconfigure the link with an ordinary register write.

All logic runs on the system clock `clk`. The serial clock, chip select and serial data input are sampled in that domain. Edges of `sclk` are found by comparing `sclk` with its value one clock earlier. Input data is sampled on rising `sclk` edges, and read data is updated after falling `sclk` edges.

Top module: `serial_reg_port`

## Requirements
- R1: After reset the control value is 24'h000300: mode field bits 11:9 = 3'b001 (self-calibration), bipolar bit 8 = 1, and every other bit 0. Both output enables are low.
- R2: The first eight rising `sclk` edges after `csN` falls carry the instruction, always MSB first. Bit 7 is the direction (0 = read, 1 = write). Bits 6:5 are the byte count (0 → 1 byte, 1 → 2 bytes, 2 or 3 → 3 bytes). Bits 2:0 are the address (0 = result word, 1 = control register). A read of any other address returns zeros.
- R3: Each data byte of a write to address 1 is stored into its byte lane of the control register, bits 8b+7..8b, once its eighth bit is sampled. The control value changes only on such an edge.
- R4: With control bit 2 clear, the data bytes of an N-byte access go to lanes N-1 down to 0. With bit 2 set, they go to lanes 0 up to N-1.
- R5: With control bit 1 clear, data bits travel MSB first. With it set, they travel LSB first. This holds for both reads and writes.
- R6: With control bit 0 clear, read data is driven on `sdioOut` with `sdioOe` high. With bit 0 set, read data is driven on `sdoOut` with `sdoOe` high. The two enables are never high together.
- R7: Read data changes only in response to a falling `sclk` edge, so it holds steady for the host's next rising-edge sample. Read data is correct whether `sclk` idles low or high.
- R8: Both output enables are low whenever no read data is being driven: while `csN` is high and after the last data bit of a transaction.
- R9: A write addressed to the result word (address 0) leaves the control value unchanged. Later reads of address 0 still return `resultIn`.
- R10: Raising `csN` part-way through a transaction abandons it. Bytes already completed are kept, a partial byte is discarded, and the next transaction starts with a fresh instruction.
- R11: Changes to control bits 2:0 take effect only from the transaction after the one that wrote them.
- R12: Read data is a snapshot taken when the instruction completes. Changes on `resultIn` during the data phase do not alter the bits being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| csN | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial clock from the host |
| sdioIn | input | 1 | Serial data received on the shared line |
| sdioOut | output | 1 | Read data for the shared line |
| sdioOe | output | 1 | Drive enable for the shared line |
| sdoOut | output | 1 | Read data for the dedicated output line |
| sdoOe | output | 1 | Drive enable for the dedicated output line |
| resultIn | input | 24 | Read-only result word |
| ctrlValue | output | 24 | Current control register contents |

## Verification
The properties assume that `sclk`, `csN` and `sdioIn` are synchronous to `clk` and slow next to it. Each `sclk` level must last several clock cycles, so that every serial edge is seen as one clean transition, and `csN` must change only while `sclk` rests. The stimulus holds every `sclk` phase for four system clocks. It changes all serial inputs on the falling edge of `clk`, and moves chip select only after `sclk` has returned to its idle level. Transactions alternate between both idle levels of `sclk`, so the edge-based properties are exercised in both polarities.

// File: rtl/srp_pkg.sv
package srp_pkg;
  localparam int BYTE_W    = 8;
  localparam int NUM_BYTES = 3;
  localparam int REG_W     = BYTE_W * NUM_BYTES;

  localparam logic [REG_W-1:0] CTRL_RESET = 24'h000300;
  localparam logic [2:0]       ADDR_RESULT = 3'd0;
  localparam logic [2:0]       ADDR_CTRL   = 3'd1;

  // control bits that steer the port itself
  localparam int CFG_ASC_BIT = 2;
  localparam int CFG_LSB_BIT = 1;
  localparam int CFG_SDO_BIT = 0;

  typedef struct packed {
    logic idle;       // chip select released
    logic sample;     // rising sclk inside an active transaction
    logic instrDone;  // eighth instruction bit sampled
    logic byteDone;   // a write data byte is complete
    logic loadOut;    // falling sclk during read data phase
    logic finish;     // last data bit sampled
  } srp_strobe_t;
endpackage

// File: rtl/srp_ctrl.sv
module srp_ctrl
  import srp_pkg::*;
#(
  parameter int BIT_W  = $clog2(BYTE_W),
  parameter int BSEL_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sclk,
  input  logic              isRead,
  input  logic [BSEL_W-1:0] byteCount,
  input  logic              cfgAsc,
  output srp_strobe_t       strb,
  output logic [BSEL_W-1:0] byteSel,
  output logic [BIT_W-1:0]  bitIdx
);
  typedef enum logic [1:0] {ST_INSTR, ST_DATA, ST_DONE} state_t;

  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);

  state_t            state;
  logic              sclkQ;
  logic [BIT_W-1:0]  bitCnt;
  logic [BSEL_W-1:0] dataIdx;
  logic [BSEL_W-1:0] lastIdx;
  logic              rise, fall;

  assign rise    = sclk & ~sclkQ;
  assign fall    = ~sclk & sclkQ;
  assign lastIdx = byteCount - BSEL_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclkQ   <= 1'b0;
      state   <= ST_INSTR;
      bitCnt  <= '0;
      dataIdx <= '0;
    end else begin
      sclkQ <= sclk;
      if (csN) begin
        state   <= ST_INSTR;
        bitCnt  <= '0;
        dataIdx <= '0;
      end else if (rise) begin
        case (state)
          ST_INSTR: begin
            bitCnt <= bitCnt + BIT_W'(1);
            if (bitCnt == LAST_BIT) state <= ST_DATA;
          end
          ST_DATA: begin
            bitCnt <= bitCnt + BIT_W'(1);
            if (bitCnt == LAST_BIT) begin
              if (dataIdx == lastIdx) state <= ST_DONE;
              else dataIdx <= dataIdx + BSEL_W'(1);
            end
          end
          default: state <= ST_DONE;
        endcase
      end
    end
  end

  always_comb begin
    strb.idle      = csN;
    strb.sample    = !csN && rise && (state != ST_DONE);
    strb.instrDone = strb.sample && (state == ST_INSTR) && (bitCnt == LAST_BIT);
    strb.byteDone  = strb.sample && (state == ST_DATA) && (bitCnt == LAST_BIT) && !isRead;
    strb.finish    = strb.sample && (state == ST_DATA) && (bitCnt == LAST_BIT) && (dataIdx == lastIdx);
    strb.loadOut   = !csN && fall && (state == ST_DATA) && isRead;
  end

  assign byteSel = cfgAsc ? dataIdx : (lastIdx - dataIdx);
  assign bitIdx  = bitCnt;
endmodule

// File: rtl/srp_dp.sv
module srp_dp
  import srp_pkg::*;
#(
  parameter int BIT_W  = $clog2(BYTE_W),
  parameter int BSEL_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sdioIn,
  input  srp_strobe_t       strb,
  input  logic [BSEL_W-1:0] byteSel,
  input  logic [BIT_W-1:0]  bitIdx,
  input  logic [REG_W-1:0]  resultIn,
  output logic              isRead,
  output logic [BSEL_W-1:0] byteCount,
  output logic              cfgAsc,
  output logic              cfgSdo,
  output logic [REG_W-1:0]  ctrlValue,
  output logic              outBit,
  output logic              driving
);
  logic [BYTE_W-1:0] shiftReg, shiftNext;
  logic [NUM_BYTES-1:0][BYTE_W-1:0] ctrlBytes;
  logic [REG_W-1:0]  rdSnap;
  logic [2:0]        addr;
  logic              inData, cfgLsb;
  logic [BYTE_W-1:0] selByte;
  logic [BIT_W-1:0]  bitPos;

  // instruction always MSB first; data follows the latched bit order
  assign shiftNext = (inData && cfgLsb) ? {sdioIn, shiftReg[BYTE_W-1:1]}
                                        : {shiftReg[BYTE_W-2:0], sdioIn};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg  <= '0;
      inData    <= 1'b0;
      isRead    <= 1'b0;
      byteCount <= BSEL_W'(1);
      addr      <= '0;
      rdSnap    <= '0;
      cfgAsc    <= CTRL_RESET[CFG_ASC_BIT];
      cfgLsb    <= CTRL_RESET[CFG_LSB_BIT];
      cfgSdo    <= CTRL_RESET[CFG_SDO_BIT];
    end else if (strb.idle) begin
      inData <= 1'b0;
      cfgAsc <= ctrlValue[CFG_ASC_BIT];
      cfgLsb <= ctrlValue[CFG_LSB_BIT];
      cfgSdo <= ctrlValue[CFG_SDO_BIT];
    end else if (strb.sample) begin
      shiftReg <= shiftNext;
      if (strb.instrDone) begin
        inData    <= 1'b1;
        isRead    <= !shiftNext[7];
        byteCount <= (shiftNext[6:5] == 2'd0) ? BSEL_W'(1) :
                     (shiftNext[6:5] == 2'd1) ? BSEL_W'(2) : BSEL_W'(3);
        addr      <= shiftNext[2:0];
        rdSnap    <= (shiftNext[2:0] == ADDR_RESULT) ? resultIn :
                     (shiftNext[2:0] == ADDR_CTRL)   ? ctrlValue : '0;
      end
    end
  end

  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rstN)
        ctrlBytes[b] <= CTRL_RESET[b*BYTE_W +: BYTE_W];
      else if (strb.byteDone && addr == ADDR_CTRL && byteSel == BSEL_W'(b))
        ctrlBytes[b] <= shiftNext;
    end
  end
  assign ctrlValue = ctrlBytes;

  always_comb begin
    selByte = '0;
    for (int b = 0; b < NUM_BYTES; b++)
      if (byteSel == BSEL_W'(b)) selByte = rdSnap[b*BYTE_W +: BYTE_W];
    bitPos = cfgLsb ? bitIdx : (BIT_W'(BYTE_W - 1) - bitIdx);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outBit  <= 1'b0;
      driving <= 1'b0;
    end else if (strb.idle || strb.finish) begin
      driving <= 1'b0;
    end else if (strb.loadOut) begin
      outBit  <= selByte[bitPos];
      driving <= 1'b1;
    end
  end
endmodule

// File: rtl/serial_reg_port.sv
module serial_reg_port
  import srp_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             csN,
  input  logic             sclk,
  input  logic             sdioIn,
  output logic             sdioOut,
  output logic             sdioOe,
  output logic             sdoOut,
  output logic             sdoOe,
  input  logic [REG_W-1:0] resultIn,
  output logic [REG_W-1:0] ctrlValue
);
  localparam int BIT_W  = $clog2(BYTE_W);
  localparam int BSEL_W = $clog2(NUM_BYTES + 1);

  srp_strobe_t       strb;
  logic [BSEL_W-1:0] byteSel, byteCount;
  logic [BIT_W-1:0]  bitIdx;
  logic              isRead, cfgAsc, cfgSdo, outBit, driving;

  srp_ctrl #(.BIT_W(BIT_W), .BSEL_W(BSEL_W)) uCtrl (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk),
    .isRead(isRead), .byteCount(byteCount), .cfgAsc(cfgAsc),
    .strb(strb), .byteSel(byteSel), .bitIdx(bitIdx)
  );

  srp_dp #(.BIT_W(BIT_W), .BSEL_W(BSEL_W)) uDp (
    .clk(clk), .rstN(rstN), .sdioIn(sdioIn), .strb(strb),
    .byteSel(byteSel), .bitIdx(bitIdx), .resultIn(resultIn),
    .isRead(isRead), .byteCount(byteCount), .cfgAsc(cfgAsc), .cfgSdo(cfgSdo),
    .ctrlValue(ctrlValue), .outBit(outBit), .driving(driving)
  );

  assign sdioOut = outBit;
  assign sdoOut  = outBit;
  assign sdioOe  = driving & ~cfgSdo;
  assign sdoOe   = driving &  cfgSdo;
endmodule

// File: rtl/serial_reg_port_chk.sv
module serial_reg_port_chk (
  input logic        clk,
  input logic        rstN,
  input logic        csN,
  input logic        sclk,
  input logic        sdioOut,
  input logic        sdioOe,
  input logic        sdoOut,
  input logic        sdoOe,
  input logic [23:0] ctrlValue
);
  logic anyOe, lineBit;
  assign anyOe   = sdioOe | sdoOe;
  assign lineBit = sdioOe ? sdioOut : sdoOut;

  // R6: at most one line is driven
  assert_one_driver_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({sdioOe, sdoOe}));

  // R8: no drive while chip select is released
  assert_quiet_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    csN && $past(csN) |-> !sdioOe && !sdoOe);

  // R7: read data moves only after a falling serial clock
  assert_hold_data_R7: assert property (@(posedge clk) disable iff (!rstN)
    anyOe && $past(anyOe) && !($past(sclk, 2) && !$past(sclk)) |-> $stable(lineBit));

  // R3: control value updates only on a rising serial clock with chip select low
  assert_write_edge_R3: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(ctrlValue) |-> $past(sclk) && !$past(sclk, 2) && !$past(csN));
endmodule

bind serial_reg_port serial_reg_port_chk uChk (
  .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk),
  .sdioOut(sdioOut), .sdioOe(sdioOe), .sdoOut(sdoOut), .sdoOe(sdoOe),
  .ctrlValue(ctrlValue)
);

// File: tb/serial_reg_port_test.sv
module serial_reg_port_test;
  logic clk = 1'b0;
  logic rstN, csN, sclk, sdioIn;
  logic sdioOut, sdioOe, sdoOut, sdoOe;
  logic [23:0] resultIn, ctrlValue;

  always #5 clk = ~clk;

  serial_reg_port uut (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdioIn(sdioIn),
    .sdioOut(sdioOut), .sdioOe(sdioOe), .sdoOut(sdoOut), .sdoOe(sdoOe),
    .resultIn(resultIn), .ctrlValue(ctrlValue)
  );

  typedef struct {
    logic  val;
    logic  onSdo;
    string tag;
  } exp_t;

  exp_t        expQ[$];
  event        sampleEv;
  int          nChecks = 0;
  int          nFail = 0;
  bit          finished = 0;
  logic [23:0] ctrlModel;
  logic [23:0] wrData;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  endtask

  // monitor: compares each read bit on the selected line against the queue
  initial begin
    forever begin
      @(sampleEv);
      if (expQ.size() == 0) begin
        check(0, "R2 unexpected read bit", 0, 0);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        if (e.onSdo)
          check(sdoOe && !sdioOe && sdoOut === e.val, e.tag,
                {29'd0, sdoOe, sdioOe, sdoOut}, {29'd0, 2'b10, e.val});
        else
          check(sdioOe && !sdoOe && sdioOut === e.val, e.tag,
                {29'd0, sdioOe, sdoOe, sdioOut}, {29'd0, 2'b10, e.val});
      end
    end
  end

  // driver: one full transaction, expected read bits pushed to the scoreboard
  task automatic runCycle(input logic [7:0] instr, input bit idleHigh, input int abortBits,
                          input bit flipResult, input string tag);
    bit          isWr  = instr[7];
    int          n     = (instr[6:5] == 2'd0) ? 1 : (instr[6:5] == 2'd1) ? 2 : 3;
    logic [2:0]  addr  = instr[2:0];
    bit          asc   = ctrlModel[2];
    bit          lsb   = ctrlModel[1];
    bit          sdo   = ctrlModel[0];
    logic [23:0] expRead = (addr == 3'd0) ? resultIn : (addr == 3'd1) ? ctrlModel : 24'd0;
    int          total = 8 + 8 * n;
    int          sent  = 0;
    sclk = idleHigh;
    repeat (4) @(negedge clk);
    csN = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < total; i++) begin
      logic bitv;
      bit   isRdBit = 0;
      if (abortBits >= 0 && i == abortBits) break;
      if (i < 8) begin
        bitv = instr[7 - i];
      end else begin
        int k = (i - 8) / 8;
        int j = (i - 8) % 8;
        int b = asc ? k : n - 1 - k;
        int p = lsb ? j : 7 - j;
        if (isWr) bitv = wrData[b*8 + p];
        else begin
          bitv = 1'b0;
          isRdBit = 1;
          expQ.push_back('{expRead[b*8 + p], sdo, tag});
        end
      end
      sclk = 1'b0;
      sdioIn = bitv;
      repeat (4) @(negedge clk);
      if (isRdBit) begin
        -> sampleEv;
        #1;
      end
      sclk = 1'b1;
      repeat (4) @(negedge clk);
      sent = i + 1;
      if (i == 7 && flipResult) resultIn = ~resultIn;
    end
    sclk = idleHigh;
    repeat (4) @(negedge clk);
    csN = 1'b1;
    repeat (4) @(negedge clk);
    if (isWr && addr == 3'd1) begin
      for (int k = 0; k < n; k++) begin
        int b = asc ? k : n - 1 - k;
        if (sent - 8 >= 8 * (k + 1)) ctrlModel[b*8 +: 8] = wrData[b*8 +: 8];
      end
    end
    check(expQ.size() == 0, {tag, " read bits missing"}, expQ.size(), 0);
    check(!sdioOe && !sdoOe, "R8 outputs released", {sdioOe, sdoOe}, 0);
    check(ctrlValue == ctrlModel, {tag, " control value"}, ctrlValue, ctrlModel);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "watchdog expired", 0, 1);
    finishRun();
  end

  initial begin
    rstN = 1'b0; csN = 1'b1; sclk = 1'b0; sdioIn = 1'b0;
    resultIn = 24'd0; wrData = 24'd0; ctrlModel = 24'h000300;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(ctrlValue == 24'h000300, "R1 reset control value", ctrlValue, 24'h000300);
    check(!sdioOe && !sdoOe, "R1 reset enables", {sdioOe, sdoOe}, 0);

    runCycle(8'h41, 0, -1, 0, "R2 read control, descending MSB-first");
    resultIn = 24'hA5C381;
    runCycle(8'h40, 1, -1, 0, "R7 read result, sclk idle high");
    wrData = 24'h123400;
    runCycle(8'hC1, 0, -1, 0, "R3 three-byte write");
    wrData = 24'h000006;
    runCycle(8'h81, 1, -1, 0, "R4 one-byte write selects ascending LSB-first");
    runCycle(8'h41, 1, -1, 0, "R5 read control LSB-first");
    runCycle(8'h21, 0, -1, 0, "R4 two-byte ascending read");
    wrData = 24'h000007;
    runCycle(8'h81, 0, -1, 0, "R6 select dedicated output");
    runCycle(8'h40, 0, -1, 0, "R6 read result on dedicated line");
    wrData = 24'hFFFFFF;
    runCycle(8'hC0, 0, -1, 0, "R9 write to result ignored");
    runCycle(8'h40, 1, -1, 0, "R9 result still readable");
    wrData = 24'h005A00;
    runCycle(8'hA1, 0, -1, 0, "R11 config change mid-transaction");
    runCycle(8'h41, 0, -1, 0, "R11 new config on next transaction");
    wrData = 24'h00C3FF;
    runCycle(8'hA1, 1, 19, 0, "R10 aborted write");
    runCycle(8'h41, 0, -1, 0, "R10 transaction after abort");
    resultIn = 24'h3C0F96;
    runCycle(8'h40, 0, -1, 1, "R12 snapshot while result changes");
    runCycle(8'h25, 1, -1, 0, "R2 unmapped address reads zero");
    finishRun();
  end
endmodule